// File: doc/BRIEF.md
# Instruction Skip-Pattern Sequencer

This block decides, slot by slot, which of the instructions that follow a skip instruction are suppressed in a small in-order core. The skip instruction presents a bit pattern and a mode. From then on each pattern bit, taken lowest bit first, stands for one following instruction. A set bit means that instruction must not take effect. The sequencer tracks the bits that remain and drives four things: a cancel flag for the slot now in execute, a fetch offset that the core adds to its program counter, a flag that shows skipping is still in progress, and an interrupt hold.

There are two modes. In the cancelling (slow) mode every suppressed instruction is fetched and uses its slot, and the sequencer only marks it as cancelled. In the look-ahead (fast) mode the sequencer counts the run of set bits at the front of the pattern and gives that count as a fetch offset. The suppressed instructions are then never fetched. Look-ahead only works from local memory. While code runs from the shared memory, fast mode falls back to cancelling. A taken branch in fast mode drops the rest of the pattern, so the fetch goes to the branch target exactly. A taken branch in slow mode does not stop the pattern, and it keeps using one bit per slot.

Top module: `skp_seq`

## Requirements
- R1: After reset no skip is active: fetch offset 0, cancel 0, active 0 and interrupt hold 0.
- R2: In slow mode the k-th slot retired after a load (k counted from 0) is cancelled exactly when pattern bit k is 1. For example, pattern 0x0E cancels the second, third and fourth slots and leaves the first and fifth to run.
- R3: In slow mode the remaining pattern moves on by exactly one bit for each retire strobe. It does not move in cycles without a retire or a load.
- R4: In fast mode from local memory, the fetch offset equals the number of consecutive 1 bits that start at the lowest remaining bit (up to the full pattern width), and cancel stays 0.
- R5: In fast mode from local memory, a retire uses up one bit plus the fetch offset in bits.
- R6: While the shared-memory flag is high, fast mode acts exactly like slow mode: the offset is 0, cancel follows the bits, and there is one bit per retire.
- R7: In fast mode from local memory, a retire with the branch-taken flag drives the fetch offset to 0 in that cycle and clears all remaining bits.
- R8: In slow mode a retire with the branch-taken flag uses up one bit as usual, and skipping carries on after the branch.
- R9: Active is high exactly while any pattern bit remains. Interrupt hold is high while active is high or a load strobe is present.
- R10: A load replaces any pattern still in progress and takes the new mode. A load has priority over a retire in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Skip instruction executes: take pattern_i and fast_i |
| pattern_i | input | PAT_W | Skip pattern, bit 0 for the first following instruction |
| fast_i | input | 1 | 1 selects look-ahead mode, 0 selects cancelling mode |
| retire_i | input | 1 | One instruction slot completes |
| branch_i | input | 1 | The retiring instruction takes a branch |
| shared_i | input | 1 | Code is fetched from the shared, slower memory |
| fetch_ofs_o | output | $clog2(PAT_W+1) | Offset that is added to the program counter for the next fetch |
| cancel_o | output | 1 | The slot now in execute must be cancelled |
| active_o | output | 1 | Pattern bits remain |
| irq_hold_o | output | 1 | Interrupts, including debug, must be held off |

## Verification
The bench targets an all-ones pattern in fast mode. A run counter that stops one short would leave a final bit behind, and active would then stay high for an extra slot. It also checks the mode fallback from shared memory, where a design that ignores the flag would give a non-zero offset and fail to cancel. It drives branches in both modes. A design that clears on a slow-mode branch loses the cancels after the jump, and one that keeps the pattern across a fast-mode branch suppresses the wrong instructions at the target. Loads that land during an active pattern, or together with a retire, show whether a design merges the old bits or lets the retire win.

// File: rtl/skp_pkg.sv
package skp_pkg;
   typedef enum logic {
      SKP_SLOW = 1'b0,
      SKP_FAST = 1'b1
   } skp_mode_e;
endpackage

// File: rtl/skp_runlen.sv
// Counts the consecutive ones at the bottom of a vector.
module skp_runlen #(
   parameter int W  = 32,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec_i,
   output logic [CW-1:0] cnt_o
);
   logic [W-1:0] run;

   assign run[0] = vec_i[0];
   for (genvar g = 1; g < W; g++) begin : g_chain
      assign run[g] = run[g-1] & vec_i[g];
   end

   always_comb begin
      cnt_o = '0;
      for (int i = 0; i < W; i++) begin
         cnt_o = cnt_o + CW'(run[i]);
      end
   end
endmodule

// File: rtl/skp_next.sv
// Next-state function for the remaining pattern.
module skp_next #(
   parameter int W    = 32,
   parameter int CW   = $clog2(W + 1),
   parameter int SH_W = $clog2(W + 2)
) (
   input  logic [W-1:0]  pat_i,
   input  logic [CW-1:0] run_i,
   input  logic          fast_i,
   input  logic          retire_i,
   input  logic          branch_i,
   output logic [W-1:0]  pat_o
);
   logic [SH_W-1:0] step;

   always_comb begin
      step  = fast_i ? (SH_W'(run_i) + SH_W'(1)) : SH_W'(1);
      pat_o = pat_i;
      if (retire_i) begin
         if (fast_i && branch_i) pat_o = '0;
         else                    pat_o = pat_i >> step;
      end
   end
endmodule

// File: rtl/skp_seq.sv
module skp_seq #(
   parameter int PAT_W   = 32,
   parameter bit FAST_EN = 1'b1,
   localparam int CW     = $clog2(PAT_W + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [PAT_W-1:0]  pattern_i,
   input  logic              fast_i,
   input  logic              retire_i,
   input  logic              branch_i,
   input  logic              shared_i,
   output logic [CW-1:0]     fetch_ofs_o,
   output logic              cancel_o,
   output logic              active_o,
   output logic              irq_hold_o
);
   import skp_pkg::*;

   if (PAT_W < 2) begin : g_bad_width
      $error("skp_seq: PAT_W must be at least 2");
   end

   logic [PAT_W-1:0] pat_q, pat_nx;
   skp_mode_e        mode_q;
   logic             eff_fast;
   logic [CW-1:0]    run;

   if (FAST_EN) begin : g_fast
      assign eff_fast = (mode_q == SKP_FAST) && !shared_i;
   end else begin : g_slow_only
      assign eff_fast = 1'b0;
   end

   skp_runlen #(.W(PAT_W), .CW(CW)) u_runlen (
      .vec_i (pat_q),
      .cnt_o (run)
   );

   skp_next #(.W(PAT_W), .CW(CW)) u_next (
      .pat_i    (pat_q),
      .run_i    (run),
      .fast_i   (eff_fast),
      .retire_i (retire_i),
      .branch_i (branch_i),
      .pat_o    (pat_nx)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pat_q  <= '0;
         mode_q <= SKP_SLOW;
      end else if (load_i) begin
         pat_q  <= pattern_i;
         mode_q <= fast_i ? SKP_FAST : SKP_SLOW;
      end else begin
         pat_q  <= pat_nx;
      end
   end

   assign fetch_ofs_o = (eff_fast && !branch_i) ? run : '0;
   assign cancel_o    = pat_q[0] && !eff_fast;
   assign active_o    = |pat_q;
   assign irq_hold_o  = active_o || load_i;
endmodule

// File: rtl/skp_seq_chk.sv
module skp_seq_chk #(
   parameter int PAT_W = 32,
   localparam int CW   = $clog2(PAT_W + 1)
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             load_i,
   input logic             retire_i,
   input logic             branch_i,
   input logic             shared_i,
   input logic             eff_fast,
   input logic [PAT_W-1:0] pat_q,
   input logic [CW-1:0]    fetch_ofs_o,
   input logic             cancel_o,
   input logic             active_o,
   input logic             irq_hold_o
);
   p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_o || load_i) |-> irq_hold_o);

   p_cancel_needs_active_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cancel_o |-> active_o);

   p_idle_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !retire_i) |=> $stable(pat_q));

   p_no_cancel_fast_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eff_fast |-> !cancel_o);

   p_shared_no_offset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shared_i |-> (fetch_ofs_o == '0));

   p_branch_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eff_fast && retire_i && branch_i && !load_i) |=> !active_o);

   p_slow_one_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!eff_fast && retire_i && !load_i) |=>
         ($countones(pat_q) + int'($past(pat_q[0])) == $countones($past(pat_q))));
endmodule

bind skp_seq skp_seq_chk #(.PAT_W(PAT_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .load_i      (load_i),
   .retire_i    (retire_i),
   .branch_i    (branch_i),
   .shared_i    (shared_i),
   .eff_fast    (eff_fast),
   .pat_q       (pat_q),
   .fetch_ofs_o (fetch_ofs_o),
   .cancel_o    (cancel_o),
   .active_o    (active_o),
   .irq_hold_o  (irq_hold_o)
);

// File: tb/tb_skp_seq.sv
module tb_skp_seq;
   localparam int W  = 8;
   localparam int CW = $clog2(W + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load = 1'b0, fast = 1'b0, retire = 1'b0, branch = 1'b0, shared = 1'b0;
   logic [W-1:0]  pattern = '0;
   logic [CW-1:0] ofs;
   logic          cancel, active, hold;

   int total = 0, bad = 0;
   bit finished = 0;

   logic [W-1:0] m_pat = '0;
   bit           m_fast = 0;

   always #4 clk = ~clk;

   skp_seq #(.PAT_W(W)) dut (
      .clk_i(clk), .rst_ni(rst_n), .load_i(load), .pattern_i(pattern),
      .fast_i(fast), .retire_i(retire), .branch_i(branch), .shared_i(shared),
      .fetch_ofs_o(ofs), .cancel_o(cancel), .active_o(active), .irq_hold_o(hold)
   );

   function automatic int lead_ones(logic [W-1:0] v);
      int n = 0;
      while (n < W && v[n]) n++;
      return n;
   endfunction

   task automatic check(string req, int act, int exp, string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Drive one cycle (inputs set after a falling edge), check, then update the model.
   task automatic cyc(bit ld, logic [W-1:0] p, bit f, bit rt, bit br, bit sh, string req);
      bit   ef;
      int   run;
      load = ld; pattern = p; fast = f; retire = rt; branch = br; shared = sh;
      #1;
      ef  = m_fast && !sh;
      run = lead_ones(m_pat);
      check(req, int'(ofs), (ef && !br) ? run : 0, "offset");
      check(req, int'(cancel), (!ef && m_pat[0]) ? 1 : 0, "cancel");
      check("R9", int'(active), (m_pat != 0) ? 1 : 0, "active");
      check("R9", int'(hold), (m_pat != 0 || ld) ? 1 : 0, "irq_hold");
      @(posedge clk);
      if (ld) begin
         m_pat = p; m_fast = f;
      end else if (rt) begin
         if (ef) m_pat = br ? '0 : W'(m_pat >> (run + 1));
         else    m_pat = m_pat >> 1;
      end
      @(negedge clk);
   endtask

   initial begin
      #(8 * 190000);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R1", int'(ofs), 0, "offset");
      check("R1", int'(cancel), 0, "cancel");
      check("R1", int'(active), 0, "active");
      check("R1", int'(hold), 0, "irq_hold");
      rst_n = 1'b1;
      @(negedge clk);

      // R2 directed: 0x0E cancels slots 2..4 (1-based)
      cyc(1, 8'h0E, 0, 1, 0, 0, "R10");
      for (int k = 0; k < 5; k++) begin
         check("R2", int'(cancel), (k >= 1 && k <= 3) ? 1 : 0, "seq_0x0E");
         cyc(0, '0, 0, 1, 0, 0, "R2");
      end

      // R3: no retire holds the pattern
      cyc(1, 8'h05, 0, 0, 0, 0, "R10");
      for (int k = 0; k < 3; k++) cyc(0, '0, 0, 0, 0, 0, "R3");
      for (int k = 0; k < 4; k++) cyc(0, '0, 0, 1, 0, 0, "R3");

      // Exhaustive sweep: all patterns, slow / fast / fast-on-shared
      for (int md = 0; md < 3; md++) begin
         for (int p = 0; p < (1 << W); p++) begin
            cyc(1, W'(p), md != 0, 0, 0, md == 2,
                md == 0 ? "R2" : (md == 1 ? "R4" : "R6"));
            for (int s = 0; s < W + 1; s++)
               cyc(0, '0, 0, 1, 0, md == 2, md == 1 ? "R5" : "R3");
         end
      end

      // R8: slow branches every other slot, pattern continues
      for (int p = 1; p < (1 << W); p += 7) begin
         cyc(1, W'(p), 0, 0, 0, 0, "R8");
         for (int s = 0; s < W + 1; s++) cyc(0, '0, 0, 1, s[0], 0, "R8");
      end

      // R7: fast branch clears remaining bits and zeroes offset
      cyc(1, 8'b1110_0110, 1, 0, 0, 0, "R7");
      cyc(0, '0, 0, 1, 1, 0, "R7");
      check("R7", int'(active), 0, "active_after_branch");
      cyc(1, 8'b0000_0011, 1, 0, 0, 0, "R7");
      cyc(0, '0, 0, 1, 1, 0, "R7");
      check("R7", int'(active), 0, "active_after_branch2");

      // R11-style edge: all ones fast, offset = W, one retire clears
      cyc(1, 8'hFF, 1, 0, 0, 0, "R4");
      check("R4", int'(ofs), W, "all_ones_offset");
      cyc(0, '0, 0, 1, 0, 0, "R5");
      check("R5", int'(active), 0, "all_ones_cleared");

      // R10: load mid-pattern replaces; load beats retire
      cyc(1, 8'hFF, 0, 0, 0, 0, "R10");
      cyc(0, '0, 0, 1, 0, 0, "R10");
      cyc(1, 8'h01, 1, 1, 0, 0, "R10");
      check("R10", int'(cancel), 0, "fast_after_reload");
      check("R10", int'(ofs), 1, "offset_after_reload");
      cyc(0, '0, 0, 1, 0, 0, "R10");
      check("R10", int'(active), 0, "done_after_reload");

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule